// File: doc/BRIEF.md
# Constant-Off-Time Current Limiter

This block sits between the current comparators of a motor bridge and its gate drive. When the load current reaches the regulation level, it asks the gate drive to switch the whole bridge off for a fixed number of clock cycles. The bridge then resumes, and the load current ramps up again. The result is current regulation with a constant off-time.

Every commanded output transition opens a blanking window. The end of every off-time also opens one. While a window is open, the regulation comparator is ignored, so switching spikes cannot start a false off-time. The two short-circuit comparators are never blanked. A trip on either one sends a single-cycle fault pulse to the downstream latch-off logic.

When the junction is in its foldback temperature region, regulation follows a comparator with a lower threshold. Outside that region it follows the normal comparator. All windows are parameters counted in clock cycles.

Top module: `offlim_top`

## Requirements
- R1: When the selected limit comparator is sampled high while the limiter is idle, `gateOff` rises at that clock edge and stays high for exactly OFF_CYCLES cycles.
- R2: A sample with `edgePulse` high opens a blanking window. The limit comparator is ignored in that sample and in the next BLANK_CYCLES-1 samples, and it is honoured from the sample after that. An `edgePulse` during a window restarts it.
- R3: The end of an off-time opens a blanking window of the same length. While the comparator stays tripped, `gateOff` is therefore low for exactly BLANK_CYCLES cycles between two off-times, and never for fewer.
- R4: Limit trips and `edgePulse` samples during an off-time have no effect. The off-time keeps its full length.
- R5: With `foldbackHot` high, only `ilimReduced` can trigger regulation. With it low, only `ilimNormal` can.
- R6: A rise of `shortHigh` OR `shortLow` while `bridgeActive` is high gives `shortFault` high for one cycle after that edge. This holds in any limiter state, including blanking and the off-time. A held short gives a single pulse.
- R7: A sample with `bridgeActive` low returns the limiter to idle. `gateOff`, `regulating` and `shortFault` are then low after that edge, and neither comparator has any effect.
- R8: `regulating` is high from the edge that starts an off-time through the blanking window that follows it. It falls at the edge where the limiter returns to idle.
- R9: While `rstN` is low, `gateOff`, `regulating` and `shortFault` are low, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bridgeActive | input | 1 | Bridge enabled and not disabled |
| edgePulse | input | 1 | One-cycle pulse on each commanded output transition |
| ilimNormal | input | 1 | Normal regulation comparator |
| ilimReduced | input | 1 | Reduced (foldback) regulation comparator |
| foldbackHot | input | 1 | Junction is in the foldback region |
| shortHigh | input | 1 | High-side short comparator |
| shortLow | input | 1 | Low-side short comparator |
| gateOff | output | 1 | Request to switch all bridge gates off |
| shortFault | output | 1 | One-cycle short-circuit fault pulse |
| regulating | output | 1 | Current regulation in progress |

## Verification
The bench builds the limiter with BLANK_CYCLES=6 and OFF_CYCLES=10 rather than the defaults of 33 and 41. With these values, a held overload runs through several complete off/blank periods in a few dozen cycles. Because the two values differ, swapping the two windows would be visible. Off-by-one errors at either window boundary would also be visible: the bench drives a trip on the last ignored sample and on the first honoured sample.

// File: rtl/offlim_pkg.sv
package offlim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_OFF   = 2'd2
  } limState_t;

  typedef struct packed {
    logic loadBlank;
    logic loadOff;
    logic countDown;
  } ctrlStrobe_t;
endpackage

// File: rtl/offlim_datapath.sv
module offlim_datapath
  import offlim_pkg::*;
#(
  parameter int BLANK_CYCLES = 33,
  parameter int OFF_CYCLES   = 41
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bridgeActive,
  input  logic        ilimNormal,
  input  logic        ilimReduced,
  input  logic        foldbackHot,
  input  logic        shortHigh,
  input  logic        shortLow,
  input  ctrlStrobe_t strobe,
  output logic        limTrip,
  output logic        timerDone,
  output logic        shortFault
);
  localparam int MAX_CYC = (BLANK_CYCLES > OFF_CYCLES) ? BLANK_CYCLES : OFF_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] BLANK_LOAD = CNT_W'(BLANK_CYCLES - 1);
  localparam logic [CNT_W-1:0] OFF_LOAD   = CNT_W'(OFF_CYCLES - 1);

  logic [CNT_W-1:0] winCnt;
  logic             shortRaw;
  logic             shortPrev;

  // threshold selection by junction temperature region
  assign limTrip   = foldbackHot ? ilimReduced : ilimNormal;
  assign timerDone = (winCnt == '0);
  assign shortRaw  = shortHigh | shortLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (!bridgeActive) begin
      winCnt <= '0;
    end else if (strobe.loadBlank) begin
      winCnt <= BLANK_LOAD;
    end else if (strobe.loadOff) begin
      winCnt <= OFF_LOAD;
    end else if (strobe.countDown && !timerDone) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  // short comparators bypass blanking; one pulse per rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortPrev  <= 1'b0;
      shortFault <= 1'b0;
    end else begin
      shortPrev  <= shortRaw;
      shortFault <= bridgeActive & shortRaw & ~shortPrev;
    end
  end
endmodule

// File: rtl/offlim_ctrl.sv
module offlim_ctrl
  import offlim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bridgeActive,
  input  logic        edgePulse,
  input  logic        limTrip,
  input  logic        timerDone,
  output ctrlStrobe_t strobe,
  output logic        gateOff,
  output logic        regulating
);
  limState_t curState, nxtState;

  always_comb begin
    nxtState = curState;
    strobe   = '0;
    if (!bridgeActive) begin
      nxtState = ST_IDLE;
    end else begin
      unique case (curState)
        ST_IDLE: begin
          if (edgePulse) begin
            nxtState = ST_BLANK;
            strobe.loadBlank = 1'b1;
          end else if (limTrip) begin
            nxtState = ST_OFF;
            strobe.loadOff = 1'b1;
          end
        end
        ST_BLANK: begin
          if (edgePulse) begin
            strobe.loadBlank = 1'b1;
          end else if (timerDone) begin
            if (limTrip) begin
              nxtState = ST_OFF;
              strobe.loadOff = 1'b1;
            end else begin
              nxtState = ST_IDLE;
            end
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        ST_OFF: begin
          if (timerDone) begin
            nxtState = ST_BLANK;
            strobe.loadBlank = 1'b1;
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        default: nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= ST_IDLE;
      regulating <= 1'b0;
    end else begin
      curState <= nxtState;
      if (nxtState == ST_OFF) begin
        regulating <= 1'b1;
      end else if (nxtState == ST_IDLE) begin
        regulating <= 1'b0;
      end
    end
  end

  assign gateOff = (curState == ST_OFF);
endmodule

// File: rtl/offlim_top.sv
module offlim_top
  import offlim_pkg::*;
#(
  parameter int BLANK_CYCLES = 33,
  parameter int OFF_CYCLES   = 41
) (
  input  logic clk,
  input  logic rstN,
  input  logic bridgeActive,
  input  logic edgePulse,
  input  logic ilimNormal,
  input  logic ilimReduced,
  input  logic foldbackHot,
  input  logic shortHigh,
  input  logic shortLow,
  output logic gateOff,
  output logic shortFault,
  output logic regulating
);
  ctrlStrobe_t strobe;
  logic        limTrip;
  logic        timerDone;

  offlim_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bridgeActive(bridgeActive),
    .edgePulse   (edgePulse),
    .limTrip     (limTrip),
    .timerDone   (timerDone),
    .strobe      (strobe),
    .gateOff     (gateOff),
    .regulating  (regulating)
  );

  offlim_datapath #(
    .BLANK_CYCLES(BLANK_CYCLES),
    .OFF_CYCLES  (OFF_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .bridgeActive(bridgeActive),
    .ilimNormal  (ilimNormal),
    .ilimReduced (ilimReduced),
    .foldbackHot (foldbackHot),
    .shortHigh   (shortHigh),
    .shortLow    (shortLow),
    .strobe      (strobe),
    .limTrip     (limTrip),
    .timerDone   (timerDone),
    .shortFault  (shortFault)
  );
endmodule

// File: rtl/offlim_checker.sv
module offlim_checker #(
  parameter int BLANK_CYCLES = 33,
  parameter int OFF_CYCLES   = 41
) (
  input logic clk,
  input logic rstN,
  input logic bridgeActive,
  input logic shortHigh,
  input logic shortLow,
  input logic gateOff,
  input logic shortFault,
  input logic regulating
);
  localparam int MAX_CYC = (BLANK_CYCLES > OFF_CYCLES) ? BLANK_CYCLES : OFF_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 2);

  logic [CNT_W-1:0] offRun;
  logic [CNT_W-1:0] gapRun;
  logic             gatePrev;
  logic             activePrev;
  logic             gapArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offRun     <= '0;
      gapRun     <= '0;
      gatePrev   <= 1'b0;
      activePrev <= 1'b0;
      gapArmed   <= 1'b0;
    end else begin
      gatePrev   <= gateOff;
      activePrev <= bridgeActive;
      if (gateOff) offRun <= (offRun == CNT_W'(MAX_CYC + 1)) ? offRun : offRun + 1'b1;
      else         offRun <= '0;
      if (!gateOff) gapRun <= (gapRun == CNT_W'(MAX_CYC + 1)) ? gapRun : gapRun + 1'b1;
      else          gapRun <= '0;
      if (!bridgeActive) gapArmed <= 1'b0;
      else if (gatePrev && !gateOff && activePrev) gapArmed <= 1'b1;
    end
  end

  // R1: off-time never exceeds its length
  p_off_max_r1: assert property (@(posedge clk) disable iff (!rstN)
    gateOff |-> (offRun < CNT_W'(OFF_CYCLES)));

  // R1: an off-time ended by the timer lasted its full length
  p_off_full_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateOff) && $past(bridgeActive)) |-> (offRun == CNT_W'(OFF_CYCLES)));

  // R3: minimum low gap between two off-times
  p_min_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateOff) && gapArmed) |-> (gapRun >= CNT_W'(BLANK_CYCLES)));

  // R6: a rising short while active yields a fault pulse
  p_short_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((shortHigh || shortLow) && !$past(shortHigh || shortLow) && bridgeActive) |=> shortFault);

  // R6: the fault is a single-cycle pulse
  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    shortFault |=> !shortFault);

  // R7: an inactive bridge clears every output
  p_inactive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !bridgeActive |=> (!gateOff && !shortFault && !regulating));

  // R8: an off-time always shows as regulation
  p_reg_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    gateOff |-> regulating);
endmodule

bind offlim_top offlim_checker #(
  .BLANK_CYCLES(BLANK_CYCLES),
  .OFF_CYCLES  (OFF_CYCLES)
) u_offlim_checker (
  .clk         (clk),
  .rstN        (rstN),
  .bridgeActive(bridgeActive),
  .shortHigh   (shortHigh),
  .shortLow    (shortLow),
  .gateOff     (gateOff),
  .shortFault  (shortFault),
  .regulating  (regulating)
);

// File: tb/test_offlim_top.sv
module test_offlim_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK_N    = 6;
  localparam int OFF_N      = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bridgeActive = 1'b0;
  logic edgePulse = 1'b0;
  logic ilimNormal = 1'b0;
  logic ilimReduced = 1'b0;
  logic foldbackHot = 1'b0;
  logic shortHigh = 1'b0;
  logic shortLow = 1'b0;
  logic gateOff;
  logic shortFault;
  logic regulating;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  expGate;
    logic  expReg;
    logic  expFault;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  offlim_top #(
    .BLANK_CYCLES(BLANK_N),
    .OFF_CYCLES  (OFF_N)
  ) i_offlim_top (
    .clk         (clk),
    .rstN        (rstN),
    .bridgeActive(bridgeActive),
    .edgePulse   (edgePulse),
    .ilimNormal  (ilimNormal),
    .ilimReduced (ilimReduced),
    .foldbackHot (foldbackHot),
    .shortHigh   (shortHigh),
    .shortLow    (shortLow),
    .gateOff     (gateOff),
    .shortFault  (shortFault),
    .regulating  (regulating)
  );

  // monitor: compares outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if ({gateOff, regulating, shortFault} !== {it.expGate, it.expReg, it.expFault}) begin
        errors++;
        $display("FAIL %s: gate/reg/fault actual=%b%b%b expected=%b%b%b",
                 it.req, gateOff, regulating, shortFault,
                 it.expGate, it.expReg, it.expFault);
      end
    end
  end

  // driver: applies inputs for one edge and queues the outputs expected after it
  task automatic step(input logic act, input logic edg, input logic lim,
                      input logic red, input logic hot, input logic sh,
                      input logic sl, input logic eGate, input logic eReg,
                      input logic eFault, input string req);
    expItem_t it;
    @(negedge clk);
    bridgeActive = act;
    edgePulse    = edg;
    ilimNormal   = lim;
    ilimReduced  = red;
    foldbackHot  = hot;
    shortHigh    = sh;
    shortLow     = sl;
    it.expGate  = eGate;
    it.expReg   = eReg;
    it.expFault = eFault;
    it.req      = req;
    expQ.push_back(it);
  endtask

  // rest of an off-time, its blanking window, then idle
  task automatic drain(input int offLeft, input string req);
    for (int i = 0; i < offLeft; i++) step(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, req);
    for (int i = 0; i < BLANK_N; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 blank after off");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 back to idle");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs low despite active inputs
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R9 reset");
    @(negedge clk);
    rstN = 1'b1;
    edgePulse = 1'b0;
    ilimNormal = 1'b0;
    ilimReduced = 1'b0;
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle after reset");

    // R1/R4/R3: held overload, edge during off ignored
    step(1, 0, 1, 0, 0, 0, 0, 1, 1, 0, "R1 trip starts off");
    for (int i = 0; i < OFF_N - 1; i++)
      step(1, (i == 3), 1, 0, 0, 0, 0, 1, 1, 0, "R4 off ignores trip and edge");
    for (int i = 0; i < BLANK_N; i++) step(1, 0, 1, 0, 0, 0, 0, 0, 1, 0, "R3 blank after off");
    step(1, 0, 1, 0, 0, 0, 0, 1, 1, 0, "R3 retrip after blank");
    drain(OFF_N - 1, "R1 second off");

    // R2: transition blanking, trip honoured on first sample after window
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R2 trip with edge ignored");
    for (int i = 0; i < BLANK_N - 1; i++) step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 trip in blank ignored");
    step(1, 0, 1, 0, 0, 0, 0, 1, 1, 0, "R2 trip after blank");
    drain(OFF_N - 1, "R1 off after blank");

    // R2: edge during window restarts it
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 first edge");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 blank");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 restart edge");
    for (int i = 0; i < BLANK_N - 1; i++) step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 restarted window");
    step(1, 0, 1, 0, 0, 0, 0, 1, 1, 0, "R2 trip after restarted window");
    drain(OFF_N - 1, "R1 off");

    // R5: threshold selection by foldback flag
    step(1, 0, 1, 0, 1, 0, 0, 0, 0, 0, "R5 normal ignored when hot");
    step(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R5 reduced ignored when cool");
    step(1, 0, 0, 1, 1, 0, 0, 1, 1, 0, "R5 reduced trips when hot");
    drain(OFF_N - 1, "R5 off");

    // R6: short faults
    step(1, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R6 high-side short");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R6 held short single pulse");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 short released");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6 edge opens blank");
    step(1, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R6 low-side short in blank");
    for (int i = 0; i < BLANK_N; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 blank runs out");
    step(1, 0, 1, 0, 0, 0, 0, 1, 1, 0, "R1 trip");
    step(1, 0, 0, 0, 0, 1, 0, 1, 1, 1, "R6 short during off");
    drain(OFF_N - 2, "R6 off continues");

    // R7: disable mid off-time
    step(1, 0, 1, 0, 0, 0, 0, 1, 1, 0, "R1 trip");
    step(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R1 off");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 disable clears");
    step(0, 0, 1, 0, 0, 1, 0, 0, 0, 0, "R7 inactive trip and short ignored");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 held short no pulse");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 idle");
    step(1, 0, 1, 0, 0, 0, 0, 1, 1, 0, "R7 trip after re-enable");
    drain(OFF_N - 1, "R7 off");

    while (expQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule